// File: doc/BRIEF.md
# System Control Register File

This block is a bank of general-purpose 32-bit control words behind a 4 KB byte-addressed window, reached over a plain single-cycle register bus. Every access finishes with no wait states. A write is taken on the clock edge where `reg_wr` is high. A read is taken on the edge where `reg_rd` is high, and its data appears on `reg_rdata` after that edge. `reg_rdata` keeps its last value until the next read. Bus transfers carry no handshake, so there is no back-pressure: the block accepts every cycle. The two request outputs are plain control pins.

Most words are ordinary storage. The block holds 512 words, so the upper 2 KB of the window aliases onto the lower 2 KB for storage. The special decodes below always use the full word address.

- Four words near the start of the second 256-byte page come out of reset with fixed identification values.
- Three of those words always read back with two status bits forced high.
- One command word, high in the window, turns particular written codes into one-cycle requests for a platform reset or a power-off.

A later stage acts on those requests.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset the stored words hold these values: byte offset 0x100 holds 0x05F20121, 0x104 holds 0x00000002, 0x108 holds 0x05F30121 and 0x10C holds 0x05F40121. With R5 applied, reads of these offsets return 0x35F20121, 0x00000002, 0x35F30121 and 0x35F40121.
- R2: After reset every other stored word is zero. `reg_rdata`, `sys_reset_req` and `sys_off_req` are zero while reset is held.
- R3: The word index for storage is byte address bits [10:2]. Bits [1:0] and bit 11 play no part in storage, so offsets 0x800 apart share one word. A written value reads back unchanged, unless R5 applies.
- R4: Read data appears on `reg_rdata` in the cycle after the edge that takes `reg_rd`. In cycles that take no read, `reg_rdata` holds its previous value.
- R5: A read whose word address (bits [11:2]) equals that of 0x100, 0x108 or 0x10C returns the stored word OR 0x30000000. The stored word is not changed by this. A read of 0x104, or of an alias such as 0x900, returns the stored value only.
- R6: Writing 1 or 2 to byte offset 0xF00 (word address bits [11:2] = 0x3C0) drives `sys_reset_req` high for exactly the one cycle after the write edge.
- R7: Writing 3 to byte offset 0xF00 drives `sys_off_req` high for exactly the one cycle after the write edge.
- R8: Writing any other value to 0xF00, or writing to its storage alias 0x700, raises no request. The value written to 0xF00 is stored like any other write and reads back.
- R9: A read and a write to the same word in the same cycle return the value held before the write. The written value is visible on the next read.
- R10: `sys_reset_req` and `sys_off_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 12 | Byte address within the window |
| reg_wr | input | 1 | Write strobe, one word per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| sys_reset_req | output | 1 | One-cycle platform reset request |
| sys_off_req | output | 1 | One-cycle power-off request |

## Verification
The bench sweeps every stored word after reset. A wrong initial value, or a force applied to the wrong word such as 0x104, shows up as a single mismatched word.

It writes zero into each forced word to separate the OR from storage. A design that folded the forced bits into the stored word, or applied them to the alias at 0x900, fails that read.

The command word is driven with each trigger code, with neighbouring non-trigger codes, with back-to-back triggers and through its storage alias. A decoder that looked at the stored word rather than the write, or at the index without bit 11, would fire at the wrong time.

A read and a write to the same word in the same cycle, followed by idle cycles, expose a read path that forwards the new data or lets the read data drift while no read is taken.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  // Byte offsets with special behaviour
  localparam logic [31:0] OFF_ID_A   = 32'h0000_0100;
  localparam logic [31:0] OFF_ID_B   = 32'h0000_0104;
  localparam logic [31:0] OFF_ID_C   = 32'h0000_0108;
  localparam logic [31:0] OFF_ID_D   = 32'h0000_010C;
  localparam logic [31:0] OFF_CMD    = 32'h0000_0F00;

  // Status bits forced on when the flagged words are read
  localparam logic [31:0] FORCE_MASK = 32'h3000_0000;

  // Command codes
  localparam logic [31:0] CODE_RST_A = 32'd1;
  localparam logic [31:0] CODE_RST_B = 32'd2;
  localparam logic [31:0] CODE_OFF   = 32'd3;

  typedef enum logic [1:0] {
    REQ_NONE  = 2'b00,
    REQ_RESET = 2'b01,
    REQ_OFF   = 2'b10
  } sys_req_e;

  // Reset contents by word index
  function automatic logic [31:0] word_init(int unsigned idx);
    case (idx)
      OFF_ID_A >> 2: word_init = 32'h05F2_0121;
      OFF_ID_B >> 2: word_init = 32'h0000_0002;
      OFF_ID_C >> 2: word_init = 32'h05F3_0121;
      OFF_ID_D >> 2: word_init = 32'h05F4_0121;
      default:       word_init = 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0] words [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    localparam logic [DATA_W-1:0] INIT = DATA_W'(word_init(i));
    always_ff @(posedge clk) begin
      if (!rst_n)
        words[i] <= INIT;
      else if (wr_en && (wr_idx == IDX_W'(i)))
        words[i] <= wr_data;
    end
  end

  assign rd_word = words[rd_idx];

endmodule

// File: rtl/sysctl_rdpath.sv
module sysctl_rdpath
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WA_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [WA_W-1:0]   rd_waddr,
  input  logic [DATA_W-1:0] raw_word,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [WA_W-1:0] WA_A = WA_W'(OFF_ID_A >> 2);
  localparam logic [WA_W-1:0] WA_C = WA_W'(OFF_ID_C >> 2);
  localparam logic [WA_W-1:0] WA_D = WA_W'(OFF_ID_D >> 2);
  localparam logic [DATA_W-1:0] MASK = DATA_W'(FORCE_MASK);

  logic forced;
  assign forced = (rd_waddr == WA_A) || (rd_waddr == WA_C) || (rd_waddr == WA_D);

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata <= '0;
    else if (rd_en)
      rdata <= raw_word | (forced ? MASK : '0);
  end

  assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  assert_force_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && ((rd_waddr == WA_A) || (rd_waddr == WA_C) || (rd_waddr == WA_D))
    |=> ((rdata & MASK) == MASK));

endmodule

// File: rtl/sysctl_cmd.sv
module sysctl_cmd
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WA_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WA_W-1:0]   wr_waddr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              reset_req,
  output logic              off_req
);

  localparam logic [WA_W-1:0] WA_CMD = WA_W'(OFF_CMD >> 2);

  sys_req_e decoded, req_q;

  always_comb begin
    decoded = REQ_NONE;
    if (wr_en && (wr_waddr == WA_CMD)) begin
      if ((wr_data == DATA_W'(CODE_RST_A)) || (wr_data == DATA_W'(CODE_RST_B)))
        decoded = REQ_RESET;
      else if (wr_data == DATA_W'(CODE_OFF))
        decoded = REQ_OFF;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= REQ_NONE;
    else        req_q <= decoded;
  end

  assign reset_req = (req_q == REQ_RESET);
  assign off_req   = (req_q == REQ_OFF);

  assert_req_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reset_req, off_req}));

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sys_reset_req,
  output logic              sys_off_req
);

  localparam int WA_W  = ADDR_W - 2;
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [WA_W-1:0] WA_CMD = WA_W'(32'h0F00 >> 2);

  logic [WA_W-1:0]   waddr;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] raw_word;
  logic              unused_low_bits;

  assign waddr = reg_addr[ADDR_W-1:2];
  assign idx   = reg_addr[IDX_W+1:2];
  assign unused_low_bits = &{1'b0, reg_addr[1:0]};

  sysctl_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .wr_idx  (idx),
    .wr_data (reg_wdata),
    .rd_idx  (idx),
    .rd_word (raw_word)
  );

  sysctl_rdpath #(.DATA_W(DATA_W), .WA_W(WA_W)) u_rdpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (reg_rd),
    .rd_waddr (waddr),
    .raw_word (raw_word),
    .rdata    (reg_rdata)
  );

  sysctl_cmd #(.DATA_W(DATA_W), .WA_W(WA_W)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr),
    .wr_waddr  (waddr),
    .wr_data   (reg_wdata),
    .reset_req (sys_reset_req),
    .off_req   (sys_off_req)
  );

  assert_reset_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> $past(reg_wr) && ($past(waddr) == WA_CMD)
                      && ($past(reg_wdata) inside {DATA_W'(1), DATA_W'(2)}));

  assert_off_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_off_req |-> $past(reg_wr) && ($past(waddr) == WA_CMD)
                    && ($past(reg_wdata) == DATA_W'(3)));

endmodule

// File: tb/tb_sysctl_regfile.sv
module tb_sysctl_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        sys_reset_req, sys_off_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] model [512];
  logic [31:0] exp_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_regfile dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .sys_reset_req(sys_reset_req), .sys_off_req(sys_off_req)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One bus cycle; compares every output at the following negedge
  task automatic step(input string tag, input logic wr, input logic rd,
                      input logic [11:0] a, input logic [31:0] d);
    logic [9:0]  wa;
    logic [8:0]  ix;
    logic        e_rst, e_off;
    reg_addr = a; reg_wr = wr; reg_wdata = d; reg_rd = rd;
    @(posedge clk);
    wa = a[11:2];
    ix = a[10:2];
    e_rst = wr && (wa == 10'h3C0) && (d == 32'd1 || d == 32'd2);
    e_off = wr && (wa == 10'h3C0) && (d == 32'd3);
    if (rd)
      exp_rdata = model[ix] |
                  ((wa == 10'h040 || wa == 10'h042 || wa == 10'h043) ? 32'h3000_0000 : 32'h0);
    if (wr) model[ix] = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    chk(tag, "rdata", reg_rdata, exp_rdata);
    chk(tag, "reset_req", {31'b0, sys_reset_req}, {31'b0, e_rst});
    chk(tag, "off_req", {31'b0, sys_off_req}, {31'b0, e_off});
  endtask

  function automatic string tag_of(input int unsigned i);
    return (i >= 'h40 && i <= 'h43) ? "R1" : "R2";
  endfunction

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (model[i]) model[i] = 32'h0;
    model['h40] = 32'h05F2_0121;
    model['h41] = 32'h0000_0002;
    model['h42] = 32'h05F3_0121;
    model['h43] = 32'h05F4_0121;

    repeat (3) @(negedge clk);
    // R2: outputs quiet during reset
    chk("R2", "rdata in reset", reg_rdata, 32'h0);
    chk("R2", "reset_req in reset", {31'b0, sys_reset_req}, 32'h0);
    chk("R2", "off_req in reset", {31'b0, sys_off_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2: sweep every stored word
    for (int unsigned i = 0; i < 512; i++)
      step(tag_of(i), 1'b0, 1'b1, 12'(i << 2), 32'h0);

    // R3: plain storage, low address bits ignored, alias across bit 11
    step("R3", 1'b1, 1'b0, 12'h024, 32'hDEAD_BEEF);
    step("R3", 1'b0, 1'b1, 12'h027, 32'h0);
    step("R3", 1'b1, 1'b0, 12'h7FD, 32'hA5A5_5A5A);
    step("R3", 1'b0, 1'b1, 12'hFFC, 32'h0);
    step("R3", 1'b1, 1'b0, 12'h200, 32'h0000_0001);
    step("R3", 1'b0, 1'b1, 12'h200, 32'h0);

    // R4: data holds while no read is taken
    step("R4", 1'b0, 1'b0, 12'h000, 32'h0);
    step("R4", 1'b1, 1'b0, 12'h200, 32'h1234_0000);
    step("R4", 1'b0, 1'b0, 12'h100, 32'h0);

    // R5: forced bits on read only
    step("R5", 1'b1, 1'b0, 12'h100, 32'h0);
    step("R5", 1'b0, 1'b1, 12'h100, 32'h0);
    step("R5", 1'b0, 1'b1, 12'h900, 32'h0);
    step("R5", 1'b1, 1'b0, 12'h104, 32'h0);
    step("R5", 1'b0, 1'b1, 12'h104, 32'h0);
    step("R5", 1'b1, 1'b0, 12'h10C, 32'hC000_0003);
    step("R5", 1'b0, 1'b1, 12'h10E, 32'h0);
    step("R5", 1'b1, 1'b0, 12'h108, 32'hFFFF_FFFF);
    step("R5", 1'b0, 1'b1, 12'h108, 32'h0);

    // R6 / R7 / R8 / R10: command codes, back to back and through the alias
    step("R6", 1'b1, 1'b0, 12'hF00, 32'd1);
    step("R6", 1'b1, 1'b0, 12'hF00, 32'd2);
    step("R7", 1'b1, 1'b0, 12'hF00, 32'd3);
    step("R10", 1'b1, 1'b0, 12'hF03, 32'd1);
    step("R8", 1'b0, 1'b1, 12'hF00, 32'h0);
    step("R8", 1'b1, 1'b0, 12'hF00, 32'd0);
    step("R8", 1'b1, 1'b0, 12'hF00, 32'd4);
    step("R8", 1'b1, 1'b0, 12'hF00, 32'h0000_0101);
    step("R8", 1'b1, 1'b0, 12'h700, 32'd3);
    step("R8", 1'b1, 1'b0, 12'h700, 32'd1);
    step("R8", 1'b0, 1'b1, 12'hF00, 32'h0);
    step("R7", 1'b1, 1'b0, 12'hF00, 32'd3);
    step("R8", 1'b0, 1'b0, 12'h000, 32'h0);

    // R9: read and write of one word in one cycle
    step("R9", 1'b1, 1'b1, 12'h300, 32'h5555_AAAA);
    step("R9", 1'b0, 1'b1, 12'h300, 32'h0);
    step("R9", 1'b1, 1'b1, 12'h108, 32'h0);
    step("R9", 1'b0, 1'b1, 12'h108, 32'h0);
    step("R9", 1'b1, 1'b1, 12'hF00, 32'd2);
    step("R4", 1'b0, 1'b0, 12'h000, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule